// File: doc/BRIEF.md
# Prioritized Interrupt Recognition Controller

This block sits between seven active-low interrupt request lines and a processor core. Each line stands for one priority level, 1 (lowest) through 7 (highest). Every line passes through a two-flop synchronizer. It must then be seen asserted on two consecutive samples before it counts as a valid request. Valid requests stay pending until the core signals a point where it may be interrupted. That point is either an instruction-boundary strobe or the completion of the exception currently being processed. At that point the block picks the highest eligible level and emits a one-cycle take pulse that carries the level.

The core owns a 3-bit priority mask. Levels 1 to 6 are level sensitive, and they are eligible only while their level is above the mask. Level 7 cannot be masked and is edge triggered. It raises a new request only when the line first becomes valid, or when the mask is written while the line is still held low. When the core acknowledges a taken interrupt, it returns the serviced level. The block then loads that level into the mask and, for level 7, clears the pending edge flag.

Top module: `irq_recognizer`

## Requirements
- R1: When several eligible requests exist at a strobe, `take_lvl` is the highest one, coded as the plain binary level number (1 to 7). `req_n[i]` carries level i+1.
- R2: A request on level 1 to 6 is taken only if its level is strictly greater than the current mask value. This holds for every mask value from 0 to 7.
- R3: A pending level-7 request is taken at any mask value, including 7.
- R4: A line counts only after two consecutive low samples at the synchronizer output. A low pulse that covers a single sampling edge never produces a take.
- R5: Level 7 raises one request per falling transition. A line held low after that request has been acknowledged raises no further request.
- R6: Any mask write while the level-7 line is validly low raises a new level-7 request. This holds for every written value, including 7.
- R7: `take` is high for exactly one cycle, in the cycle after a clock edge that samples `bnd_stb` or `exc_done` high while an eligible request exists and no take is awaiting acknowledge. Without such a strobe, `take` stays low.
- R8: `ack` loads `ack_lvl` into the mask, and an `ack_lvl` of 7 clears the level-7 pending flag. After a take, no further take occurs until `ack` is seen.
- R9: A level 1 to 6 request that is released before a strobe is dropped and produces no take.
- R10: Reset sets the mask to 7, clears all pending state, and leaves `take` low. A level-7 line already held low through reset does not produce a request.
- R11: `mask_wr` loads `mask_wdata` into the mask. If `ack` is high in the same cycle, the acknowledged level is loaded instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_n | input | 7 | Active-low request lines; bit i is level i+1 |
| mask_wr | input | 1 | Mask write strobe from the core |
| mask_wdata | input | 3 | Mask value to write |
| bnd_stb | input | 1 | Instruction-boundary strobe |
| exc_done | input | 1 | Current exception processing finished |
| ack | input | 1 | Acknowledge of the taken interrupt |
| ack_lvl | input | 3 | Level being acknowledged |
| take | output | 1 | One-cycle take-interrupt pulse |
| take_lvl | output | 3 | Level chosen for the take |
| mask | output | 3 | Current priority mask |

## Verification
The assertions assume the core acknowledges only a level that was actually taken, and sends at most one acknowledge per take. They also assume that a source releases its line only once its level has been acknowledged or has been abandoned on purpose. The stimulus changes inputs only on falling clock edges. It acknowledges every take with the level it reports, and it waits long enough after each release for the synchronizer and qualifier to drain before the next pattern. Glitches and early releases are applied on purpose, with no acknowledge pending.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned NLVL  = 7;
  localparam int unsigned LVL_W = $clog2(NLVL + 1);

  // lines eligible for a take: levels 1..6 above the mask, level 7 always
  function automatic logic [NLVL-1:0] eligible(input logic [NLVL-2:0] qual,
                                                input logic            nmi,
                                                input logic [LVL_W-1:0] msk);
    logic [NLVL-1:0] e;
    for (int i = 0; i < NLVL - 1; i++)
      e[i] = qual[i] && (LVL_W'(i + 1) > msk);
    e[NLVL-1] = nmi;
    return e;
  endfunction

  // binary level number of the highest set bit, 0 when none
  function automatic logic [LVL_W-1:0] highest(input logic [NLVL-1:0] v);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = 0; i < NLVL; i++)
      if (v[i]) r = LVL_W'(i + 1);
    return r;
  endfunction
endpackage

// File: rtl/irqc_sync_qual.sv
module irqc_sync_qual #(
  parameter int unsigned        N          = 7,
  parameter int unsigned        STAGES     = 2,
  parameter logic [N-1:0]       RST_ACTIVE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_n,
  output logic [N-1:0] qual
);
  logic [N-1:0] act;
  logic [N-1:0] hist;

  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{~RST_ACTIVE[g]}};
      else        chain <= {chain[STAGES-2:0], req_n[g]};
    end
    assign act[g] = ~chain[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist[g] <= RST_ACTIVE[g];
      else        hist[g] <= act[g];
    end
    assign qual[g] = act[g] & hist[g];

    // R4: a qualified line was also active on the previous sample
    p_two_samples_r4: assert property (@(posedge clk) disable iff (!rst_n)
      qual[g] |-> $past(act[g]));
  end
endmodule

// File: rtl/irqc_nmi_edge.sv
module irqc_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic qual7,
  input  logic mask_wr,
  input  logic clr,
  output logic pend
);
  logic prev;
  logic rise_evt;
  logic rearm_evt;

  assign rise_evt  = qual7 & ~prev;
  assign rearm_evt = mask_wr & qual7;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b1;
      pend <= 1'b0;
    end else begin
      prev <= qual7;
      if (rise_evt || rearm_evt) pend <= 1'b1;
      else if (clr)              pend <= 1'b0;
    end
  end

  p_pend_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt || rearm_evt) |=> pend);
  // R5: a new pending flag only follows an edge or a rearming write
  p_pend_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(rise_evt || rearm_evt));
endmodule

// File: rtl/irqc_select.sv
module irqc_select
  import irqc_pkg::*;
(
  input  logic [NLVL-2:0]  qual_lo,
  input  logic             nmi_pend,
  input  logic [LVL_W-1:0] msk,
  output logic             sel_any,
  output logic [LVL_W-1:0] sel_lvl
);
  logic [NLVL-1:0] elig;
  always_comb begin
    elig    = eligible(qual_lo, nmi_pend, msk);
    sel_any = |elig;
    sel_lvl = highest(elig);
  end
endmodule

// File: rtl/irq_recognizer.sv
module irq_recognizer
  import irqc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLVL-1:0]  req_n,
  input  logic             mask_wr,
  input  logic [LVL_W-1:0] mask_wdata,
  input  logic             bnd_stb,
  input  logic             exc_done,
  input  logic             ack,
  input  logic [LVL_W-1:0] ack_lvl,
  output logic             take,
  output logic [LVL_W-1:0] take_lvl,
  output logic [LVL_W-1:0] mask
);
  localparam logic [NLVL-1:0] RST_ACT = NLVL'(1) << (NLVL - 1);
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NLVL);

  logic [NLVL-1:0]  qual;
  logic             nmi_pend;
  logic             nmi_clr;
  logic             sel_any;
  logic [LVL_W-1:0] sel_lvl;
  logic             wait_q;
  logic             take_evt;

  irqc_sync_qual #(.N(NLVL), .STAGES(SYNC_STAGES), .RST_ACTIVE(RST_ACT)) u_sq (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .qual(qual));

  assign nmi_clr = ack && (ack_lvl == TOP_LVL);

  irqc_nmi_edge u_nmi (
    .clk(clk), .rst_n(rst_n), .qual7(qual[NLVL-1]), .mask_wr(mask_wr),
    .clr(nmi_clr), .pend(nmi_pend));

  irqc_select u_sel (
    .qual_lo(qual[NLVL-2:0]), .nmi_pend(nmi_pend), .msk(mask),
    .sel_any(sel_any), .sel_lvl(sel_lvl));

  assign take_evt = (bnd_stb || exc_done) && !wait_q && sel_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask     <= TOP_LVL;
      take     <= 1'b0;
      take_lvl <= '0;
      wait_q   <= 1'b0;
    end else begin
      take <= 1'b0;
      if (ack) begin
        mask   <= ack_lvl;
        wait_q <= 1'b0;
      end else if (mask_wr) begin
        mask <= mask_wdata;
      end
      if (take_evt) begin
        take     <= 1'b1;
        take_lvl <= sel_lvl;
        wait_q   <= 1'b1;
      end
    end
  end

  p_take_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);
  p_take_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take) |-> $past(bnd_stb || exc_done));
  p_take_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> take_lvl != '0);
  p_above_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_lvl != TOP_LVL) |-> take_lvl > $past(mask));
  p_nmi_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend |-> sel_lvl == TOP_LVL);
  p_ack_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> mask == $past(ack_lvl));
endmodule

// File: tb/sim_irq_recognizer.sv
module sim_irq_recognizer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] req_n = 7'h7f;
  logic       mask_wr = 1'b0;
  logic [2:0] mask_wdata = '0;
  logic       bnd_stb = 1'b0;
  logic       exc_done = 1'b0;
  logic       ack = 1'b0;
  logic [2:0] ack_lvl = '0;
  logic       take;
  logic [2:0] take_lvl;
  logic [2:0] mask;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_recognizer u0 (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .bnd_stb(bnd_stb), .exc_done(exc_done),
    .ack(ack), .ack_lvl(ack_lvl), .take(take), .take_lvl(take_lvl),
    .mask(mask));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_mask(input logic [2:0] m);
    mask_wr = 1'b1; mask_wdata = m;
    cyc(1);
    mask_wr = 1'b0;
    check(mask == m, "R11 mask write", mask, m);
  endtask

  task automatic do_ack(input logic [2:0] l);
    ack = 1'b1; ack_lvl = l;
    cyc(1);
    ack = 1'b0;
    check(mask == l, "R8 ack loads mask", mask, l);
  endtask

  // strobe once; expect a take of lvl (0 = no take); acknowledge if taken
  task automatic strobe(input int lvl, input string req, input bit use_done = 1'b0);
    if (use_done) exc_done = 1'b1; else bnd_stb = 1'b1;
    cyc(1);
    bnd_stb = 1'b0; exc_done = 1'b0;
    check(take == (lvl != 0), req, take, lvl != 0);
    if (lvl != 0) begin
      check(take_lvl == 3'(lvl), req, take_lvl, lvl);
      cyc(1);
      check(take == 1'b0, "R7 one-cycle take", take, 0);
      do_ack(3'(lvl));
    end
  endtask

  function automatic int top_of(input int pat);
    int r = 0;
    for (int i = 0; i < 7; i++) if (pat[i]) r = i + 1;
    return r;
  endfunction

  initial begin
    // R10: line 7 held low through reset
    req_n = 7'h3f;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    check(mask == 3'd7, "R10 reset mask", mask, 7);
    check(take == 1'b0, "R10 reset take", take, 0);
    cyc(6);
    strobe(0, "R10 held line at reset no request");
    // R6: mask write while held re-arms, value 7
    write_mask(3'd7);
    cyc(1);
    strobe(7, "R6 rearm by write of 7");
    // R5: held line, no retrigger
    cyc(4);
    strobe(0, "R5 held level 7 no retrigger");
    write_mask(3'd3);
    cyc(1);
    strobe(7, "R6 rearm by write of 3");
    req_n = 7'h7f; cyc(5);
    // R3: fresh edge at mask 7
    check(mask == 3'd7, "R3 mask at 7", mask, 7);
    req_n = 7'h3f; cyc(5);
    strobe(7, "R3 level 7 at mask 7");
    req_n = 7'h7f; cyc(5);

    // R2: mask sweep for levels 1..6
    for (int m = 0; m < 8; m++) begin
      for (int l = 1; l < 7; l++) begin
        write_mask(3'(m));
        req_n = 7'h7f & ~(7'd1 << (l - 1));
        cyc(5);
        strobe((l > m) ? l : 0, "R2 mask sweep");
        req_n = 7'h7f; cyc(4);
      end
    end

    // R1: every combination of levels 1..6, plus level 7 mixes
    for (int p = 1; p < 64; p++) begin
      write_mask(3'd0);
      req_n = ~7'(p);
      cyc(5);
      strobe(top_of(p), "R1 priority");
      req_n = 7'h7f; cyc(4);
    end
    write_mask(3'd0);
    req_n = 7'h1e; cyc(5);
    strobe(7, "R1 level 7 beats level 6");
    req_n = 7'h7f; cyc(4);

    // R4: one-sample glitch
    write_mask(3'd0);
    req_n = 7'h7b; cyc(1); req_n = 7'h7f;
    cyc(5);
    strobe(0, "R4 glitch ignored");
    req_n = 7'h3f; cyc(1); req_n = 7'h7f;
    cyc(5);
    strobe(0, "R4 level 7 glitch ignored");

    // R9: released before strobe
    req_n = 7'h77; cyc(5);
    req_n = 7'h7f; cyc(4);
    strobe(0, "R9 released request dropped");

    // R7: no take without strobe, then exc_done
    write_mask(3'd0);
    req_n = 7'h7d; cyc(5);
    for (int k = 0; k < 4; k++) begin
      check(take == 1'b0, "R7 no strobe no take", take, 0);
      cyc(1);
    end
    exc_done = 1'b1; cyc(1); exc_done = 1'b0;
    check(take == 1'b1 && take_lvl == 3'd2, "R7 take on exc_done", take_lvl, 2);
    // R8: no second take before ack
    cyc(1);
    bnd_stb = 1'b1; cyc(1); bnd_stb = 1'b0;
    check(take == 1'b0, "R8 no take before ack", take, 0);
    // R11: ack and mask write together, ack wins
    ack = 1'b1; ack_lvl = 3'd2; mask_wr = 1'b1; mask_wdata = 3'd5;
    cyc(1);
    ack = 1'b0; mask_wr = 1'b0;
    check(mask == 3'd2, "R11 ack beats mask write", mask, 2);
    req_n = 7'h7f; cyc(4);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule